// File: doc/BRIEF.md
# Differential Receive Pair Boundary Scan Stage

This block is the boundary scan stage for one differential receive pair that feeds a double-data-rate input path. It holds two capture/shift/update scan cells. One watches the positive pin and the other watches the negative pin. The two cells are chained in series between the serial test input and the serial test output. The TAP controller drives them through the usual data-register strobes. All state changes on the rising edge of the test clock. The capture strobe acts as a clock enable, and the shift select picks between loading the pin level and loading the previous cell.

The block has two modes, chosen by the `intest` input, and it has no state machine of its own. In NORMAL mode, the core-facing rising-edge and falling-edge outputs pass the receiver's DDR samples through unchanged. In INTEST mode, both core outputs are driven from the positive-pin cell's update latch. This gives the core a single-data-rate value that can be scanned in. When a valid differential signal is present, the two captured pin values are complements of each other, so scanning out the pair shows whether the pair is healthy.

Top module: `diff_rx_bscan`

## Requirements
- R1: While `rst_n` is low, and right after it is released, every shift stage and update latch is 0. As a result `tdo` reads 0 and, in INTEST mode, both core outputs read 0.
- R2: On a rising `clk` edge with `clock_dr`=1 and `shift_dr`=0, the positive cell loads `pin_p` and the negative cell loads `pin_n`. `tdo` then shows the negative cell's captured value.
- R3: On a rising `clk` edge with `clock_dr`=1 and `shift_dr`=1, the positive cell loads `tdi` and the negative cell loads the positive cell's previous value. The scan order is `tdi` → positive cell → negative cell → `tdo`, and `tdo` is the negative cell's shift stage.
- R4: On an edge with `clock_dr`=0, both shift stages hold their values, whatever `tdi`, `shift_dr` or the pins do.
- R5: Each update latch loads its cell's shift stage, as it was before the edge, only on an edge with `update_dr`=1. It holds its value on every other edge.
- R6: While `intest`=1, `core_rise` and `core_fall` both equal the positive cell's update latch.
- R7: While `intest`=0, `core_rise` equals `rise_in` and `core_fall` equals `fall_in`, combinationally.
- R8: The negative cell's update latch never reaches the core outputs. A value updated into it has no effect on `core_rise` or `core_fall`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_p | input | 1 | Positive pin level from the receiver |
| pin_n | input | 1 | Negative pin level from the receiver |
| rise_in | input | 1 | Rising-edge DDR sample from the receiver |
| fall_in | input | 1 | Falling-edge DDR sample from the receiver |
| tdi | input | 1 | Serial scan input |
| clock_dr | input | 1 | Capture/shift enable for the shift stages |
| shift_dr | input | 1 | 1 = shift from the chain, 0 = capture the pins |
| update_dr | input | 1 | Update-latch load strobe |
| intest | input | 1 | 1 = drive the core from the update latch |
| tdo | output | 1 | Serial scan output |
| core_rise | output | 1 | Rising-edge data to the core |
| core_fall | output | 1 | Falling-edge data to the core |

## Verification
The assertions assume that every strobe and pin is stable around the rising edge of `clk`, and that the TAP controller drives `clock_dr`, `shift_dr` and `update_dr` as clean synchronous levels. They make no assumption about how the strobes are combined. The bench changes all inputs only on the falling edge. It also drives overlapping strobe combinations on purpose, such as capture and update in the same cycle, so that the update-uses-old-value rule is exercised within these assumptions.

// File: rtl/diff_bscan_pkg.sv
package diff_bscan_pkg;

    localparam int NUM_CELLS = 2;

    typedef enum logic [0:0] {
        CELL_POS = 1'b0,
        CELL_NEG = 1'b1
    } cell_idx_e;

    typedef struct packed {
        logic shift_q;
        logic upd_q;
    } cell_state_t;

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_level,
    input  logic scan_in,
    input  logic capture_en,
    input  logic shift_en,
    input  logic update_en,
    output logic scan_out,
    output logic upd_out
);
    import diff_bscan_pkg::*;

    cell_state_t st;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st.shift_q <= 1'b0;
        end else if (capture_en) begin
            st.shift_q <= shift_en ? scan_in : pin_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st.upd_q <= 1'b0;
        end else if (update_en) begin
            st.upd_q <= st.shift_q;
        end
    end

    assign scan_out = st.shift_q;
    assign upd_out  = st.upd_q;

    // R4: shift stage holds without the capture strobe
    assert_shift_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !capture_en |=> $stable(scan_out));

    // R5: update latch holds without the update strobe
    assert_upd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !update_en |=> $stable(upd_out));

    // R5: update latch takes the pre-edge shift value
    assert_upd_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        update_en |=> upd_out == $past(scan_out));

endmodule

// File: rtl/ddr_core_mux.sv
module ddr_core_mux (
    input  logic intest,
    input  logic rise_in,
    input  logic fall_in,
    input  logic inject,
    output logic core_rise,
    output logic core_fall
);
    always_comb begin
        if (intest) begin
            core_rise = inject;
            core_fall = inject;
        end else begin
            core_rise = rise_in;
            core_fall = fall_in;
        end
    end

    // R7: pass-through outside INTEST
    always_comb begin
        if (!intest) begin
            assert_pass_R7: assert (core_rise == rise_in && core_fall == fall_in);
        end
    end

endmodule

// File: rtl/diff_rx_bscan.sv
module diff_rx_bscan (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_p,
    input  logic pin_n,
    input  logic rise_in,
    input  logic fall_in,
    input  logic tdi,
    input  logic clock_dr,
    input  logic shift_dr,
    input  logic update_dr,
    input  logic intest,
    output logic tdo,
    output logic core_rise,
    output logic core_fall
);
    import diff_bscan_pkg::*;

    localparam int CHAIN_LEN = NUM_CELLS + 1;

    logic [NUM_CELLS-1:0] pins;
    logic [CHAIN_LEN-1:0] chain;
    logic [NUM_CELLS-1:0] upd;

    assign pins[CELL_POS] = pin_p;
    assign pins[CELL_NEG] = pin_n;
    assign chain[0]       = tdi;

    for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
        bscan_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_level  (pins[i]),
            .scan_in    (chain[i]),
            .capture_en (clock_dr),
            .shift_en   (shift_dr),
            .update_en  (update_dr),
            .scan_out   (chain[i+1]),
            .upd_out    (upd[i])
        );
    end

    assign tdo = chain[NUM_CELLS];

    ddr_core_mux u_mux (
        .intest    (intest),
        .rise_in   (rise_in),
        .fall_in   (fall_in),
        .inject    (upd[CELL_POS]),
        .core_rise (core_rise),
        .core_fall (core_fall)
    );

    // R2: capture loads the pin levels
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clock_dr && !shift_dr |=> chain[1] == $past(pin_p) && tdo == $past(pin_n));

    // R3: shift moves tdi into the positive cell and the positive cell to tdo
    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clock_dr && shift_dr |=> chain[1] == $past(tdi) && tdo == $past(chain[1]));

    // R6: INTEST drives both core outputs from the positive update latch
    assert_intest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        intest |-> core_rise == upd[CELL_POS] && core_fall == upd[CELL_POS]);

    // R5: negative update latch holds without the update strobe
    assert_neg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !update_dr |=> $stable(upd[CELL_NEG]));

endmodule

// File: tb/diff_rx_bscan_test.sv
`timescale 1ns/100ps
module diff_rx_bscan_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_p = 0, pin_n = 0, rise_in = 0, fall_in = 0;
    logic tdi = 0, clock_dr = 0, shift_dr = 0, update_dr = 0, intest = 0;
    logic tdo, core_rise, core_fall;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_sh_p = 0, m_sh_n = 0, m_up_p = 0, m_up_n = 0;

    always #2.5 clk = ~clk;

    diff_rx_bscan uut (
        .clk(clk), .rst_n(rst_n), .pin_p(pin_p), .pin_n(pin_n),
        .rise_in(rise_in), .fall_in(fall_in), .tdi(tdi),
        .clock_dr(clock_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .intest(intest), .tdo(tdo), .core_rise(core_rise), .core_fall(core_fall)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        check(tdo, m_sh_n, "R3 tdo vs model");
        check(core_rise, intest ? m_up_p : rise_in, intest ? "R6 core_rise" : "R7 core_rise");
        check(core_fall, intest ? m_up_p : fall_in, intest ? "R6 core_fall" : "R7 core_fall");
    endtask

    // one cycle: drive at the falling edge, compare, then step the model at the rising edge
    task automatic tick(input logic t_tdi, input logic cdr, input logic sdr, input logic udr);
        bit op, on;
        tdi = t_tdi; clock_dr = cdr; shift_dr = sdr; update_dr = udr;
        #1;
        compare_model();
        @(posedge clk);
        op = m_sh_p; on = m_sh_n;
        if (udr) begin m_up_p = op; m_up_n = on; end
        if (cdr) begin
            if (sdr) begin m_sh_p = t_tdi; m_sh_n = op; end
            else     begin m_sh_p = pin_p; m_sh_n = pin_n; end
        end
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        intest = 1;
        tdi = 1; clock_dr = 1; update_dr = 1; pin_p = 1;
        repeat (3) @(negedge clk);
        check(tdo, 1'b0, "R1 tdo in reset");
        check(core_rise, 1'b0, "R1 core_rise in reset");
        check(core_fall, 1'b0, "R1 core_fall in reset");
        tdi = 0; clock_dr = 0; update_dr = 0; pin_p = 0;
        rst_n = 1;
        @(negedge clk);
        check(tdo, 1'b0, "R1 tdo after reset");
        check(core_rise, 1'b0, "R1 core_rise after reset");

        // R7: pass-through patterns
        intest = 0;
        for (int k = 0; k < 4; k++) begin
            rise_in = k[0]; fall_in = k[1];
            tick(0, 0, 0, 0);
        end

        // R2: capture complementary pair p=1 n=0
        pin_p = 1; pin_n = 0;
        tick(0, 1, 0, 0);
        check(tdo, 1'b0, "R2 negative cell captured");
        tick(0, 1, 1, 0);
        check(tdo, 1'b1, "R2 positive cell capture shifted out");
        tick(1, 1, 1, 0);
        check(tdo, 1'b0, "R3 shifted zero reaches tdo");

        // R4: hold without capture strobe, noisy inputs
        for (int k = 0; k < 4; k++) begin
            pin_p = k[0]; pin_n = ~k[0];
            tick(k[1], 0, k[0], 0);
            check(tdo, 1'b0, "R4 shift stage held");
        end

        // R5/R6: update p=1 n=0, INTEST
        intest = 1;
        tick(0, 0, 0, 1);
        check(core_rise, 1'b1, "R6 core_rise from positive latch");
        check(core_fall, 1'b1, "R6 core_fall from positive latch");

        // R5: shift without update leaves latches alone
        tick(0, 1, 1, 0);
        check(core_rise, 1'b1, "R5 latch held after shift");
        check(tdo, 1'b1, "R3 positive to negative");

        // R8: negative latch gets 1, positive gets 0
        tick(0, 0, 0, 1);
        check(core_rise, 1'b0, "R8 negative latch ignored (rise)");
        check(core_fall, 1'b0, "R8 negative latch ignored (fall)");

        // capture and update in the same cycle: update uses old value
        pin_p = 1; pin_n = 0;
        tick(0, 1, 0, 1);
        check(core_rise, 1'b0, "R5 update took pre-edge value");
        tick(0, 0, 0, 1);
        check(core_rise, 1'b1, "R5 later update loads captured pin_p");

        // R7: leave INTEST
        intest = 0; rise_in = 0; fall_in = 1;
        tick(0, 0, 0, 0);
        check(core_rise, 1'b0, "R7 core_rise pass");
        check(core_fall, 1'b1, "R7 core_fall pass");

        // R2: opposite polarity capture
        pin_p = 0; pin_n = 1;
        tick(0, 1, 0, 0);
        check(tdo, 1'b1, "R2 negative pin captured");
        tick(1, 1, 1, 0);
        check(tdo, 1'b0, "R2 positive pin complement");

        // mixed pseudo-random traffic against the model
        for (int k = 0; k < 200; k++) begin
            pin_p = k[2] ^ k[5]; pin_n = ~pin_p;
            rise_in = k[1]; fall_in = k[3] ^ k[0];
            intest = k[6];
            tick(k[0] ^ k[4], k[1] | k[3], k[0], k[2] & k[4]);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule